// File: doc/BRIEF.md
# Dual-Mode Fuzzy Defuzzifier

This block turns the activation degrees of eight output fuzzy sets into one crisp control value. Each set carries a fixed 8-bit center: set k sits at 16 + 32*k, so the centers run from 16 (set 0) to 240 (set 7). A request carries all eight 8-bit degrees and a method select. It enters through a valid/ready input stream. The result leaves through a valid/ready output stream, together with a flag that reports when no rule fired.

In peak mode the block outputs the center of the set with the largest degree. In centroid mode it forms the degree-weighted sum of the centers and divides it by the sum of the degrees. Where two sets overlap, the shared area is counted once for each set, so no overlap term is subtracted and the result is a plain weighted average. A restoring divider works out the quotient one bit per clock. The block handles one request at a time. It leaves the input stream not ready from acceptance until its result has been taken.

Top module: `defuzz_core`

## Requirements
- R1: `in_ready` is 1 only while no request is in progress. A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. While a request is in progress, `in_valid` and the values on `alpha_in` and `mode_coa` have no effect on the result.
- R2: With `mode_coa`=0 (peak mode), `crisp` equals the center 16+32*k of the set k with the largest degree. Set k's degree is `alpha_in[8k+7:8k]`.
- R3: In peak mode, when several sets share the largest degree, the set with the lowest index k wins.
- R4: With `mode_coa`=1 (centroid mode), `crisp` equals floor(sum(alpha_k*center_k) / sum(alpha_k)). Overlap is counted in full, with no correction, so `crisp` always lies between 16 and 240.
- R5: When all eight degrees are zero, `crisp` is 0 and `no_rule` is 1, in either mode. Otherwise `no_rule` is 0.
- R6: Once `out_valid` is 1, it stays 1 and `crisp` and `no_rule` stay unchanged until a rising edge where `out_ready` is 1. After that edge the block is idle again (`in_ready`=1, `out_valid`=0).
- R7: After reset, `in_ready` is 1, `out_valid` is 0, `crisp` is 0 and `no_rule` is 0.
- R8: In peak mode, `out_valid` rises on the first rising edge after the accepting edge. In centroid mode with a non-zero degree sum, it rises on the 21st rising edge after the accepting edge: one evaluation cycle, 19 divider steps and one capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_coa | input | 1 | Method select: 0 peak, 1 centroid; sampled on acceptance |
| alpha_in | input | 64 | Eight degrees; set k at bits 8k+7:8k |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to accept |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| crisp | output | 8 | Crisp output value |
| no_rule | output | 1 | All degrees were zero |

## Verification
The hardest situation to reach is a new request that arrives while a centroid division is still running. The divider is in the middle of its bit steps, and a different payload on the input stream must leave no trace in the quotient. The stimulus starts a centroid request. Then, during the division, it holds `in_valid` high with a different mode and different degrees, and checks that the result still matches the first request. Back-pressure is handled the same way: the consumer withholds `out_ready` for several cycles while the result is sampled for stability.

// File: rtl/defuzz_pkg.sv
package defuzz_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVAL,
    ST_DIV,
    ST_HOLD
  } dz_state_e;

  // Fixed center of output set k: evenly spaced from a base value.
  function automatic int unsigned set_center(int unsigned k, int unsigned base,
                                             int unsigned step);
    return base + k * step;
  endfunction

endpackage

// File: rtl/defuzz_argmax.sv
module defuzz_argmax #(
  parameter int unsigned N_SETS = 8,
  parameter int unsigned AW     = 8,
  localparam int unsigned IDX_W = $clog2(N_SETS)
) (
  input  logic [N_SETS*AW-1:0] alpha,
  output logic [IDX_W-1:0]     win_idx
);

  logic [AW-1:0] best_val;

  // Strict comparison keeps the lowest index on ties.
  always_comb begin
    win_idx  = '0;
    best_val = alpha[AW-1:0];
    for (int k = 1; k < N_SETS; k++) begin
      if (alpha[k*AW +: AW] > best_val) begin
        best_val = alpha[k*AW +: AW];
        win_idx  = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/defuzz_wsum.sv
module defuzz_wsum
  import defuzz_pkg::*;
#(
  parameter int unsigned N_SETS = 8,
  parameter int unsigned AW     = 8,
  parameter int unsigned CW     = 8,
  parameter int unsigned C_BASE = 16,
  parameter int unsigned C_STEP = 32,
  localparam int unsigned DEN_W = AW + $clog2(N_SETS),
  localparam int unsigned NUM_W = DEN_W + CW
) (
  input  logic [N_SETS*AW-1:0] alpha,
  output logic [NUM_W-1:0]     num,
  output logic [DEN_W-1:0]     den
);

  always_comb begin
    num = '0;
    den = '0;
    for (int k = 0; k < N_SETS; k++) begin
      den = den + DEN_W'(alpha[k*AW +: AW]);
      num = num + NUM_W'(alpha[k*AW +: AW]) *
                  NUM_W'(set_center(k, C_BASE, C_STEP));
    end
  end

endmodule

// File: rtl/defuzz_divider.sv
module defuzz_divider #(
  parameter int unsigned NUM_W = 19,
  parameter int unsigned DEN_W = 11,
  parameter int unsigned OUT_W = 8,
  localparam int unsigned CNT_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic [OUT_W-1:0] quotient,
  output logic             done
);

  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             done_q;

  logic [DEN_W:0]   shifted;
  logic             fits;
  logic [DEN_W-1:0] diffv;

  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    fits    = shifted >= {1'b0, den_q};
    diffv   = shifted[DEN_W-1:0] - den_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      quo_q  <= dividend;
      rem_q  <= '0;
      den_q  <= divisor;
      cnt_q  <= CNT_W'(NUM_W);
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      quo_q <= {quo_q[NUM_W-2:0], fits};
      rem_q <= fits ? diffv : shifted[DEN_W-1:0];
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign quotient = quo_q[OUT_W-1:0];
  assign done     = done_q;

endmodule

// File: rtl/defuzz_core.sv
module defuzz_core
  import defuzz_pkg::*;
#(
  parameter int unsigned N_SETS = 8,
  parameter int unsigned AW     = 8,
  parameter int unsigned CW     = 8,
  parameter int unsigned C_BASE = 16,
  parameter int unsigned C_STEP = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_coa,
  input  logic [N_SETS*AW-1:0] alpha_in,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CW-1:0]        crisp,
  output logic                 no_rule
);

  localparam int unsigned IDX_W = $clog2(N_SETS);
  localparam int unsigned DEN_W = AW + $clog2(N_SETS);
  localparam int unsigned NUM_W = DEN_W + CW;

  dz_state_e           state_q;
  logic [N_SETS*AW-1:0] alpha_q;
  logic                mode_q;
  logic [CW-1:0]       crisp_q;
  logic                norule_q;

  logic [IDX_W-1:0]    win_idx;
  logic [NUM_W-1:0]    num;
  logic [DEN_W-1:0]    den;
  logic [CW-1:0]       div_q;
  logic                div_done;
  logic                div_start;

  defuzz_argmax #(.N_SETS(N_SETS), .AW(AW)) u_argmax (
    .alpha   (alpha_q),
    .win_idx (win_idx)
  );

  defuzz_wsum #(
    .N_SETS(N_SETS), .AW(AW), .CW(CW), .C_BASE(C_BASE), .C_STEP(C_STEP)
  ) u_wsum (
    .alpha (alpha_q),
    .num   (num),
    .den   (den)
  );

  assign div_start = (state_q == ST_EVAL) && mode_q && (den != '0);

  defuzz_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .OUT_W(CW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (num),
    .divisor  (den),
    .quotient (div_q),
    .done     (div_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      alpha_q  <= '0;
      mode_q   <= 1'b0;
      crisp_q  <= '0;
      norule_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            alpha_q  <= alpha_in;
            mode_q   <= mode_coa;
            norule_q <= 1'b0;
            state_q  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (den == '0) begin
            crisp_q  <= '0;
            norule_q <= 1'b1;
            state_q  <= ST_HOLD;
          end else if (!mode_q) begin
            crisp_q <= CW'(set_center(int'(win_idx), C_BASE, C_STEP));
            state_q <= ST_HOLD;
          end else begin
            state_q <= ST_DIV;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            crisp_q <= div_q;
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign crisp     = crisp_q;
  assign no_rule   = norule_q;

endmodule

// File: rtl/defuzz_checker.sv
module defuzz_checker #(
  parameter int unsigned N_SETS = 8,
  parameter int unsigned AW     = 8,
  parameter int unsigned CW     = 8,
  parameter int unsigned C_BASE = 16,
  parameter int unsigned C_STEP = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [CW-1:0] crisp,
  input logic          no_rule
);

  localparam int unsigned NUM_W = AW + $clog2(N_SETS) + CW;
  localparam int unsigned LAT_W = $clog2(NUM_W + 8);
  localparam int unsigned C_LO  = C_BASE;
  localparam int unsigned C_HI  = C_BASE + (N_SETS - 1) * C_STEP;

  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (in_valid && in_ready) lat_q <= LAT_W'(1);
    else if (!in_ready && !out_valid) lat_q <= lat_q + 1'b1;
  end

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid); // R1

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(crisp) && $stable(no_rule)); // R6

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready); // R6

  AST_NORULE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && no_rule |-> crisp == '0); // R5

  AST_CENTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !no_rule |-> (crisp >= CW'(C_LO)) && (crisp <= CW'(C_HI))); // R4

  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_q <= LAT_W'(NUM_W + 3)); // R8

endmodule

bind defuzz_core defuzz_checker #(
  .N_SETS(N_SETS), .AW(AW), .CW(CW), .C_BASE(C_BASE), .C_STEP(C_STEP)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .crisp     (crisp),
  .no_rule   (no_rule)
);

// File: tb/tb_defuzz_core.sv
module tb_defuzz_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_coa = 1'b0;
  logic [63:0] alpha_in = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  crisp;
  logic        no_rule;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  defuzz_core dut (
    .clk(clk), .rst_n(rst_n), .mode_coa(mode_coa), .alpha_in(alpha_in),
    .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .crisp(crisp), .no_rule(no_rule)
  );

  // {mode, a7..a0, expected crisp}; centers 16+32k
  localparam logic [72:0] VEC [9] = '{
    {1'b0, 64'h00000005C8000A00, 8'd112},  // R2 peak at set 3
    {1'b0, 64'h005A0000005A0000, 8'd80},   // R3 tie sets 2/6
    {1'b0, 64'hFF000000000000FE, 8'd240},  // R2 near tie
    {1'b1, 64'h0000006400000000, 8'd144},  // R4 single set
    {1'b1, 64'h0000000000646400, 8'd64},   // R4 equal overlap
    {1'b1, 64'h0200000000000001, 8'd165},  // R4 floor 496/3
    {1'b1, 64'hFFFFFFFFFFFFFFFF, 8'd128},  // R4 all full
    {1'b1, 64'h0000009632000000, 8'd136},  // R4 27200/200
    {1'b1, 64'h0000000000000103, 8'd24}    // R4 96/4
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one request from idle; returns cycles to out_valid, result fields.
  task automatic issue(input logic m, input logic [63:0] a,
                       output int lat, output logic [7:0] c, output logic nr);
    @(negedge clk);
    mode_coa = m;
    alpha_in = a;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    c  = crisp;
    nr = no_rule;
  endtask

  task automatic take();
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [7:0] c;
    logic nr;

    repeat (3) @(negedge clk);
    // R7 reset state
    check(in_ready == 1'b1, "R7 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R7 out_valid", out_valid, 0);
    check(crisp == 8'd0, "R7 crisp", crisp, 0);
    check(no_rule == 1'b0, "R7 no_rule", no_rule, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      issue(VEC[i][72], VEC[i][71:8], lat, c, nr);
      check(c == VEC[i][7:0], VEC[i][72] ? "R4 centroid" : "R2/R3 peak",
            c, VEC[i][7:0]);
      check(nr == 1'b0, "R5 no_rule low", nr, 0);
      check(lat == (VEC[i][72] ? 21 : 1), "R8 latency", lat,
            VEC[i][72] ? 21 : 1);
      take();
      check(in_ready == 1'b1, "R6 idle after take", in_ready, 1);
    end

    // R5 all zero, both modes
    issue(1'b1, 64'h0, lat, c, nr);
    check(c == 8'd0 && nr == 1'b1, "R5 centroid zero", {nr, c}, 256);
    take();
    issue(1'b0, 64'h0, lat, c, nr);
    check(c == 8'd0 && nr == 1'b1, "R5 peak zero", {nr, c}, 256);
    take();

    // R1 request during division is ignored
    @(negedge clk);
    mode_coa = 1'b1;
    alpha_in = 64'h0000000000646400;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mode_coa = 1'b0;
    alpha_in = 64'hFF00000000000000;
    repeat (5) @(negedge clk);
    check(in_ready == 1'b0, "R1 busy not ready", in_ready, 0);
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    check(crisp == 8'd64, "R1 busy input ignored", crisp, 64);

    // R6 back-pressure: result held while out_ready low
    repeat (5) @(negedge clk);
    check(out_valid == 1'b1, "R6 out_valid held", out_valid, 1);
    check(crisp == 8'd64, "R6 crisp stable", crisp, 64);
    check(in_ready == 1'b0, "R6 not ready while held", in_ready, 0);
    take();
    check(out_valid == 1'b0 && in_ready == 1'b1, "R6 release",
          {out_valid, in_ready}, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule